// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block is the halfword control register file that sits between a processor bus and the peripheral groups of a small handheld-style system: display, sound, DMA, timers, keypad, interrupts and a debug hook. The bus writes bytes, halfwords or words and reads halfwords. Every register applies its own rule to what is stored on a write and to what is returned on a read. Some bits are writable only under a mask. Some are status bits that come from a peripheral input. Some registers are read-only, write-only or unused, and some read back as zero while sound is switched off.

The peripheral engines are not in this block. Each accepted write is reported to them on a one-cycle event channel that carries the register index and the stored value. A 32-bit write reaches two registers at once, so the channel has two lanes. Reads are registered and return one cycle after the request. Interrupt flags are set from a peripheral input and cleared by writing ones. A debug register unlocks on a magic key.

Top module: `regbank_top`

## Requirements
- R1: After reset, halfword index 0 reads 0x0080, indices 3 and 4 read 0x0100, index 8 reads 0x0200 and index 15 reads 0x03FF (while `keys_i` is all ones). All other stored registers reset to 0.
- R2: A read of halfword index `rd_addr_i[5:1]` requested in one cycle shows `rd_valid_o`=1 and the data in the next cycle. A cycle with no request gives `rd_valid_o`=0.
- R3: Writes store only the writable bits: timer controls (indices 13, 14) keep 0x00C7, keypad control (16) keeps 0xC3FF, wait control (19) keeps 0x5FFF, sound mixer (6) keeps 0x770F and interrupt enable (17) keeps 0x3FFF. The other bits keep their old values.
- R4: `wr_size_i`=0 is a byte write. `wr_addr_i[0]`=0 selects bits 7:0 and 1 selects bits 15:8, with the byte taken from `wr_data_i[7:0]`. The other byte keeps its stored value, and the merged halfword then follows the halfword write rules. `wr_size_i`=1 is a halfword write.
- R5: `wr_size_i`=2 is a word write. Bits 15:0 go to the halfword at `wr_addr_i` with bits 1:0 cleared, and bits 31:16 go to the next halfword. Both halves follow their own register rules.
- R6: The interrupt flags (index 18, bits 13:0) are set by `irq_set_i` and cleared where a 1 is written. A byte write clears only within its own byte. When a bit is set and cleared in the same cycle, the set wins.
- R7: The line counter (index 2) reads `line_i` zero-extended. Writes to it change nothing and raise no event.
- R8: The display status register (index 1) reads bits 2:0 from `disp_stat_i`. Bits 15:3 are written and stored normally.
- R9: In the sound master register (index 7), only bit 7 is stored. A read returns bit 7, returns `snd_stat_i` in bits 3:0 and returns 0 in the other bits.
- R10: While sound master bit 7 is 0, reads of the sound tone (5) and mixer (6) registers return 0. Writes to them are still stored and become visible once bit 7 is 1.
- R11: The DMA length register (11) and the reserved index 21 read 0. The write-only DMA source registers (9, 10) and indices 23 to 31 read `open_bus_i`. Writes to indices 21 and 23 to 31 raise no event.
- R12: Writing 0xC0DE to the debug register (22) turns debug mode on, and a read then returns 0x1DEA. Writing any other value turns it off, and a read then returns `open_bus_i`.
- R13: One cycle after an accepted write, `evt_valid_o` lane 0 (low half) and lane 1 (high half of a word write) pulse. Each lane carries its index in `evt_idx_o` (5 bits per lane, lane 1 in the upper bits) and its stored value in `evt_data_o` (16 bits per lane).
- R14: The key state register (15) reads `keys_i` as sampled one clock earlier, zero-extended. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| wr_addr_i | input | 6 | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 6 | Byte address of the read |
| rd_data_o | output | 16 | Read data, one cycle after the request |
| rd_valid_o | output | 1 | Read data valid |
| open_bus_i | input | 16 | Value returned for write-only and unmapped reads |
| line_i | input | 8 | Current display line |
| disp_stat_i | input | 3 | Display status bits |
| snd_stat_i | input | 4 | Sound channel status bits |
| keys_i | input | 10 | Key levels |
| irq_set_i | input | 14 | Interrupt flag set pulses |
| evt_valid_o | output | 2 | Write event per lane |
| evt_idx_o | output | 10 | Register index per lane |
| evt_data_o | output | 32 | Stored value per lane |

## Verification
The hardest case to reach is the interrupt flag register when a peripheral set and a bus clear land in the same cycle. A close second is a byte-wide clear that must leave the other byte of flags untouched. The bench raises several flags through `irq_set_i` and then clears one through an upper-lane byte write. On a separate cycle it drives a set pulse and a write of the same bit together, and then reads the flags back. Gated sound reads need an ordering too: writes land while sound is off and are read back both before and after the master bit is set.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int HW_W     = 16;
    localparam int DSTAT_W  = 3;
    localparam int SSTAT_W  = 4;
    localparam int SND_ON_BIT = 7;
    localparam logic [HW_W-1:0] DBG_KEY_VAL = 16'hC0DE;
    localparam logic [HW_W-1:0] DBG_ID_VAL  = 16'h1DEA;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // halfword indices
    localparam int IX_DISP_CTRL = 0;
    localparam int IX_DISP_STAT = 1;
    localparam int IX_LINE      = 2;
    localparam int IX_AFF_A     = 3;
    localparam int IX_AFF_D     = 4;
    localparam int IX_SND_TONE  = 5;
    localparam int IX_SND_MIX   = 6;
    localparam int IX_SND_MAIN  = 7;
    localparam int IX_SND_BIAS  = 8;
    localparam int IX_DMA_SRC_L = 9;
    localparam int IX_DMA_SRC_H = 10;
    localparam int IX_DMA_LEN   = 11;
    localparam int IX_DMA_CTL   = 12;
    localparam int IX_TMR0_CTL  = 13;
    localparam int IX_TMR1_CTL  = 14;
    localparam int IX_KEY_STATE = 15;
    localparam int IX_KEY_CTL   = 16;
    localparam int IX_IRQ_EN    = 17;
    localparam int IX_IRQ_FLAG  = 18;
    localparam int IX_WAIT_CTL  = 19;
    localparam int IX_IRQ_MAST  = 20;
    localparam int IX_RSVD      = 21;
    localparam int IX_DBG       = 22;
    localparam int IX_LAST      = 22;

    typedef enum logic [1:0] {WK_NONE, WK_MASK, WK_W1C, WK_KEY} wkind_e;
    typedef enum logic [2:0] {RK_PLAIN, RK_OPEN, RK_ZERO, RK_GATED,
                              RK_STAT, RK_LINE, RK_MAIN, RK_DBG} rkind_e;

    function automatic wkind_e wkind(input int idx);
        case (idx)
            IX_LINE, IX_KEY_STATE, IX_RSVD: return WK_NONE;
            IX_IRQ_FLAG:                    return WK_W1C;
            IX_DBG:                         return WK_KEY;
            default:                        return (idx <= IX_LAST) ? WK_MASK : WK_NONE;
        endcase
    endfunction

    function automatic logic [HW_W-1:0] wmask(input int idx);
        case (idx)
            IX_DISP_STAT:             return 16'hFFF8;
            IX_SND_MIX:               return 16'h770F;
            IX_SND_MAIN:              return 16'h0080;
            IX_TMR0_CTL, IX_TMR1_CTL: return 16'h00C7;
            IX_KEY_CTL:               return 16'hC3FF;
            IX_IRQ_EN, IX_IRQ_FLAG:   return 16'h3FFF;
            IX_WAIT_CTL:              return 16'h5FFF;
            IX_IRQ_MAST:              return 16'h0001;
            default:                  return 16'hFFFF;
        endcase
    endfunction

    function automatic rkind_e rkind(input int idx);
        case (idx)
            IX_DISP_STAT:               return RK_STAT;
            IX_LINE:                    return RK_LINE;
            IX_SND_TONE, IX_SND_MIX:    return RK_GATED;
            IX_SND_MAIN:                return RK_MAIN;
            IX_DMA_SRC_L, IX_DMA_SRC_H: return RK_OPEN;
            IX_DMA_LEN, IX_RSVD:        return RK_ZERO;
            IX_DBG:                     return RK_DBG;
            default:                    return (idx <= IX_LAST) ? RK_PLAIN : RK_OPEN;
        endcase
    endfunction

    function automatic logic [HW_W-1:0] rst_val(input int idx);
        case (idx)
            IX_DISP_CTRL:       return 16'h0080;
            IX_AFF_A, IX_AFF_D: return 16'h0100;
            IX_SND_BIAS:        return 16'h0200;
            IX_KEY_STATE:       return 16'h03FF;
            default:            return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/regbank_wlane.sv
module regbank_wlane
    import regbank_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [HW_W-1:0]  data_i,
    input  logic [1:0]       be_i,
    input  logic [HW_W-1:0]  old_i,
    output logic             hit_o,
    output logic [HW_W-1:0]  new_o
);
    wkind_e          kind;
    logic [HW_W-1:0] mask;
    logic [HW_W-1:0] base;
    logic [HW_W-1:0] merged;

    always_comb begin
        kind = wkind(int'(idx_i));
        mask = wmask(int'(idx_i));
        // flags merge against zero so the untouched byte clears nothing
        base = (kind == WK_W1C) ? '0 : old_i;
        merged[7:0]  = be_i[0] ? data_i[7:0]  : base[7:0];
        merged[15:8] = be_i[1] ? data_i[15:8] : base[15:8];
        case (kind)
            WK_MASK: new_o = (old_i & ~mask) | (merged & mask);
            WK_W1C:  new_o = old_i & ~(merged & mask);
            WK_KEY:  new_o = {15'b0, merged == DBG_KEY_VAL};
            default: new_o = old_i;
        endcase
        hit_o = en_i && (kind != WK_NONE);
    end
endmodule

// File: rtl/regbank_rmux.sv
module regbank_rmux
    import regbank_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int LINE_W = 8
) (
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [HW_W-1:0]    word_i,
    input  logic               snd_on_i,
    input  logic               dbg_on_i,
    input  logic [LINE_W-1:0]  line_i,
    input  logic [DSTAT_W-1:0] disp_stat_i,
    input  logic [SSTAT_W-1:0] snd_stat_i,
    input  logic [HW_W-1:0]    open_bus_i,
    output logic [HW_W-1:0]    data_o
);
    always_comb begin
        case (rkind(int'(idx_i)))
            RK_PLAIN: data_o = word_i;
            RK_ZERO:  data_o = '0;
            RK_GATED: data_o = snd_on_i ? word_i : '0;
            RK_STAT:  data_o = {word_i[HW_W-1:DSTAT_W], disp_stat_i};
            RK_LINE:  data_o = HW_W'(line_i);
            RK_MAIN:  data_o = {8'b0, word_i[SND_ON_BIT], 3'b0, snd_stat_i};
            RK_DBG:   data_o = dbg_on_i ? DBG_ID_VAL : open_bus_i;
            default:  data_o = open_bus_i;
        endcase
    end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LINE_W = 8,
    parameter int KEY_W  = 10,
    parameter int IRQ_W  = 14
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_size_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [31:0]           wr_data_i,
    input  logic                  rd_en_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [15:0]           rd_data_o,
    output logic                  rd_valid_o,
    input  logic [15:0]           open_bus_i,
    input  logic [LINE_W-1:0]     line_i,
    input  logic [2:0]            disp_stat_i,
    input  logic [3:0]            snd_stat_i,
    input  logic [KEY_W-1:0]      keys_i,
    input  logic [IRQ_W-1:0]      irq_set_i,
    output logic [1:0]            evt_valid_o,
    output logic [2*ADDR_W-3:0]   evt_idx_o,
    output logic [31:0]           evt_data_o
);
    localparam int IDX_W     = ADDR_W - 1;
    localparam int NUM_HW    = 1 << IDX_W;
    localparam int NUM_LANES = 2;

    typedef struct packed {
        logic [NUM_HW-1:0][HW_W-1:0]    regs;
        logic [HW_W-1:0]                rdata;
        logic                           rvalid;
        logic [NUM_LANES-1:0]           ev_v;
        logic [NUM_LANES-1:0][IDX_W-1:0] ev_i;
        logic [NUM_LANES-1:0][HW_W-1:0] ev_d;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_LANES-1:0]            lane_en;
    logic [NUM_LANES-1:0][IDX_W-1:0] lane_idx;
    logic [NUM_LANES-1:0][HW_W-1:0]  lane_data;
    logic [NUM_LANES-1:0][1:0]       lane_be;
    logic [NUM_LANES-1:0][HW_W-1:0]  lane_old;
    logic [NUM_LANES-1:0]            lane_hit;
    logic [NUM_LANES-1:0][HW_W-1:0]  lane_new;

    logic [IDX_W-1:0] rd_idx;
    logic [HW_W-1:0]  rd_word;
    logic             snd_on_q, dbg_on_q;
    logic [HW_W-1:0]  irq_flag_q, snd_main_q;

    // ---- lane setup: byte / half use lane 0, word splits over both ----
    always_comb begin
        lane_en   = '0;
        lane_idx  = '0;
        lane_data = '0;
        lane_be   = '0;
        case (wr_size_i)
            SZ_BYTE: begin
                lane_en[0]   = wr_en_i;
                lane_idx[0]  = wr_addr_i[ADDR_W-1:1];
                lane_data[0] = {wr_data_i[7:0], wr_data_i[7:0]};
                lane_be[0]   = wr_addr_i[0] ? 2'b10 : 2'b01;
            end
            SZ_HALF: begin
                lane_en[0]   = wr_en_i;
                lane_idx[0]  = wr_addr_i[ADDR_W-1:1];
                lane_data[0] = wr_data_i[15:0];
                lane_be[0]   = 2'b11;
            end
            SZ_WORD: begin
                lane_en      = {NUM_LANES{wr_en_i}};
                lane_idx[0]  = {wr_addr_i[ADDR_W-1:2], 1'b0};
                lane_idx[1]  = {wr_addr_i[ADDR_W-1:2], 1'b1};
                lane_data[0] = wr_data_i[15:0];
                lane_data[1] = wr_data_i[31:16];
                lane_be      = {NUM_LANES{2'b11}};
            end
            default: ;
        endcase
        for (int g = 0; g < NUM_LANES; g++) begin
            lane_old[g] = s_q.regs[lane_idx[g]];
        end
    end

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            regbank_wlane #(.IDX_W(IDX_W)) u_wlane (
                .en_i   (lane_en[g]),
                .idx_i  (lane_idx[g]),
                .data_i (lane_data[g]),
                .be_i   (lane_be[g]),
                .old_i  (lane_old[g]),
                .hit_o  (lane_hit[g]),
                .new_o  (lane_new[g])
            );
        end
    endgenerate

    // ---- read path ----
    assign rd_idx     = rd_addr_i[ADDR_W-1:1];
    assign rd_word    = s_q.regs[rd_idx];
    assign snd_on_q   = s_q.regs[IX_SND_MAIN][SND_ON_BIT];
    assign dbg_on_q   = s_q.regs[IX_DBG][0];
    assign irq_flag_q = s_q.regs[IX_IRQ_FLAG];
    assign snd_main_q = s_q.regs[IX_SND_MAIN];

    logic [HW_W-1:0] rd_mux;

    regbank_rmux #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_rmux (
        .idx_i       (rd_idx),
        .word_i      (rd_word),
        .snd_on_i    (snd_on_q),
        .dbg_on_i    (dbg_on_q),
        .line_i      (line_i),
        .disp_stat_i (disp_stat_i),
        .snd_stat_i  (snd_stat_i),
        .open_bus_i  (open_bus_i),
        .data_o      (rd_mux)
    );

    // ---- next state ----
    always_comb begin
        s_d = s_q;
        s_d.regs[IX_KEY_STATE] = HW_W'(keys_i);
        for (int g = 0; g < NUM_LANES; g++) begin
            if (lane_hit[g]) begin
                s_d.regs[lane_idx[g]] = lane_new[g];
            end
            s_d.ev_v[g] = lane_hit[g];
            s_d.ev_i[g] = lane_idx[g];
            s_d.ev_d[g] = lane_new[g];
        end
        // peripheral set pulses win over a same-cycle clear
        s_d.regs[IX_IRQ_FLAG] = s_d.regs[IX_IRQ_FLAG] | HW_W'(irq_set_i);
        s_d.rvalid = rd_en_i;
        if (rd_en_i) begin
            s_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_HW; i++) begin
                s_q.regs[i] <= rst_val(i);
            end
            s_q.rdata  <= '0;
            s_q.rvalid <= 1'b0;
            s_q.ev_v   <= '0;
            s_q.ev_i   <= '0;
            s_q.ev_d   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data_o   = s_q.rdata;
    assign rd_valid_o  = s_q.rvalid;
    assign evt_valid_o = s_q.ev_v;
    assign evt_idx_o   = s_q.ev_i;
    assign evt_data_o  = s_q.ev_d;

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IRQ_W  = 14
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [15:0]       rd_data_o,
    input logic              rd_valid_o,
    input logic [2:0]        disp_stat_i,
    input logic [IRQ_W-1:0]  irq_set_i,
    input logic              wr_en_i,
    input logic [1:0]        evt_valid_o,
    input logic [15:0]       irq_flag_q,
    input logic [15:0]       snd_main_q
);
    localparam int IDX_W = ADDR_W - 1;

    assert_read_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_valid_o);

    assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rd_valid_o);

    assert_flag_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_set_i != '0) |=> ((irq_flag_q[IRQ_W-1:0] & $past(irq_set_i)) == $past(irq_set_i)));

    assert_stat_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && rd_addr_i[ADDR_W-1:1] == IDX_W'(IX_DISP_STAT))
        |=> rd_data_o[2:0] == $past(disp_stat_i));

    assert_sound_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !snd_main_q[SND_ON_BIT] &&
         (rd_addr_i[ADDR_W-1:1] == IDX_W'(IX_SND_TONE) ||
          rd_addr_i[ADDR_W-1:1] == IDX_W'(IX_SND_MIX)))
        |=> rd_data_o == 16'h0000);

    assert_len_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && rd_addr_i[ADDR_W-1:1] == IDX_W'(IX_DMA_LEN)) |=> rd_data_o == 16'h0000);

    assert_event_needs_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> evt_valid_o == 2'b00);

    assert_main_only_bit7_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (snd_main_q & 16'hFF7F) == 16'h0000);
endmodule

bind regbank_top regbank_chk #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o),
    .disp_stat_i (disp_stat_i),
    .irq_set_i   (irq_set_i),
    .wr_en_i     (wr_en_i),
    .evt_valid_o (evt_valid_o),
    .irq_flag_q  (irq_flag_q),
    .snd_main_q  (snd_main_q)
);

// File: tb/regbank_top_bench.sv
module regbank_top_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_size_i = 2'd0;
    logic [5:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [5:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic        rd_valid_o;
    logic [15:0] open_bus_i = 16'hBEEF;
    logic [7:0]  line_i = '0;
    logic [2:0]  disp_stat_i = '0;
    logic [3:0]  snd_stat_i = '0;
    logic [9:0]  keys_i = 10'h3FF;
    logic [13:0] irq_set_i = '0;
    logic [1:0]  evt_valid_o;
    logic [9:0]  evt_idx_o;
    logic [31:0] evt_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk_i = ~clk_i;

    regbank_top u_regbank_top (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sz, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_size_i = sz; wr_addr_i = a; wr_data_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk_i);
        rd_en_i = 1'b1; rd_addr_i = a;
        @(negedge clk_i);
        rd_en_i = 1'b0;
        chk({tag, " valid"}, {31'b0, rd_valid_o}, 32'd1);
        chk(tag, {16'b0, rd_data_o}, {16'b0, exp});
    endtask

    task automatic t_reset;
        rd(6'd0,  16'h0080, "R1 disp ctrl");
        rd(6'd6,  16'h0100, "R1 aff a");
        rd(6'd8,  16'h0100, "R1 aff d");
        rd(6'd16, 16'h0200, "R1 bias");
        rd(6'd30, 16'h03FF, "R1 keys");
        @(negedge clk_i);
        chk("R2 idle valid", {31'b0, rd_valid_o}, 32'd0);
    endtask

    task automatic t_masks;
        wr(2'd1, 6'd26, 32'hFFFF); rd(6'd26, 16'h00C7, "R3 timer");
        wr(2'd1, 6'd32, 32'hFFFF); rd(6'd32, 16'hC3FF, "R3 keyctl");
        wr(2'd1, 6'd38, 32'hFFFF); rd(6'd38, 16'h5FFF, "R3 wait");
    endtask

    task automatic t_bytes;
        wr(2'd1, 6'd0, 32'h1234);
        wr(2'd0, 6'd1, 32'hAB);  rd(6'd0, 16'hAB34, "R4 upper byte");
        wr(2'd0, 6'd0, 32'hCD);  rd(6'd0, 16'hABCD, "R4 lower byte");
    endtask

    task automatic t_word;
        wr(2'd2, 6'd32, 32'h1111_FFFF);
        chk("R13 evt valid", {30'b0, evt_valid_o}, 32'd3);
        chk("R13 evt idx", {22'b0, evt_idx_o}, {22'b0, 5'd17, 5'd16});
        chk("R5 evt data", evt_data_o, 32'h1111_C3FF);
        rd(6'd32, 16'hC3FF, "R5 low half");
        rd(6'd34, 16'h1111, "R5 high half");
        wr(2'd2, 6'd34, 32'hFFFF_0000);
        rd(6'd34, 16'h3FFF, "R5 R3 misaligned word upper to irq en");
    endtask

    task automatic t_irq;
        @(negedge clk_i); irq_set_i = 14'h0305;
        @(negedge clk_i); irq_set_i = '0;
        rd(6'd36, 16'h0305, "R6 set");
        wr(2'd1, 6'd36, 32'h0101); rd(6'd36, 16'h0204, "R6 w1c");
        wr(2'd0, 6'd37, 32'h02);   rd(6'd36, 16'h0004, "R6 byte clear");
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_size_i = 2'd1; wr_addr_i = 6'd36; wr_data_i = 32'h0004;
        irq_set_i = 14'h0004;
        @(negedge clk_i);
        wr_en_i = 1'b0; irq_set_i = '0;
        rd(6'd36, 16'h0004, "R6 set wins");
    endtask

    task automatic t_line;
        line_i = 8'h5A;
        rd(6'd4, 16'h005A, "R7 line read");
        wr(2'd1, 6'd4, 32'hFFFF);
        chk("R7 no event", {30'b0, evt_valid_o}, 32'd0);
        rd(6'd4, 16'h005A, "R7 line after write");
    endtask

    task automatic t_dstat;
        disp_stat_i = 3'b101;
        wr(2'd1, 6'd2, 32'hFFFF); rd(6'd2, 16'hFFFD, "R8 stat");
        disp_stat_i = 3'b000;
        rd(6'd2, 16'hFFF8, "R8 stat cleared");
    endtask

    task automatic t_sound;
        snd_stat_i = 4'hA;
        wr(2'd1, 6'd10, 32'h1234);
        wr(2'd1, 6'd12, 32'hFFFF);
        rd(6'd12, 16'h0000, "R10 mix gated");
        rd(6'd10, 16'h0000, "R10 tone gated");
        wr(2'd1, 6'd14, 32'hFFFF);
        rd(6'd14, 16'h008A, "R9 main");
        rd(6'd12, 16'h770F, "R10 R3 mix");
        rd(6'd10, 16'h1234, "R10 tone");
        wr(2'd1, 6'd14, 32'h0000);
        rd(6'd10, 16'h0000, "R10 tone off again");
    endtask

    task automatic t_special;
        wr(2'd1, 6'd22, 32'h0055); rd(6'd22, 16'h0000, "R11 len zero");
        rd(6'd42, 16'h0000, "R11 reserved zero");
        wr(2'd1, 6'd18, 32'h4321); rd(6'd18, 16'hBEEF, "R11 src open bus");
        wr(2'd1, 6'd50, 32'h7777);
        chk("R11 unmapped no event", {30'b0, evt_valid_o}, 32'd0);
        rd(6'd50, 16'hBEEF, "R11 unmapped open bus");
    endtask

    task automatic t_debug;
        rd(6'd44, 16'hBEEF, "R12 locked");
        wr(2'd1, 6'd44, 32'hC0DE);
        chk("R13 dbg event", {30'b0, evt_valid_o}, 32'd1);
        rd(6'd44, 16'h1DEA, "R12 unlocked");
        wr(2'd1, 6'd44, 32'h1234); rd(6'd44, 16'hBEEF, "R12 relocked");
    endtask

    task automatic t_keys;
        keys_i = 10'h155;
        repeat (2) @(negedge clk_i);
        rd(6'd30, 16'h0155, "R14 keys");
        wr(2'd1, 6'd30, 32'h0000); rd(6'd30, 16'h0155, "R14 write ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_masks();
        t_bytes();
        t_word();
        t_irq();
        t_line();
        t_dstat();
        t_sound();
        t_special();
        t_debug();
        t_keys();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule